// File: doc/BRIEF.md
# Time-Slot Interchange Output Engine

This block produces the serial output side of a time-slot interchange switch. There are four output streams, and each stream carries 32 byte-wide time slots per frame. For every slot on every stream the engine picks the byte to send and shifts it out most significant bit first. It also drives a per-slot output-enable that models a three-state driver.

The byte comes from one of two sources. In switched mode, the slot's low connection entry gives a stream and channel address, and that address is looked up in an external receive data memory. In message mode, the low connection entry itself is the byte, and it goes out again every frame until it is rewritten.

A small high connection entry per slot holds two flags: one selects message mode and one enables the slot's driver. Two global controls sit above these flags. A broadcast-message input forces every slot into message mode with its driver on. A drive-enable pin disables every driver. The frame position is an input to the block, and so are the connection-memory writes.

Top module: `tsi_out_engine`

## Requirements
- R1: After reset, every output-enable is 0 and every serial data output is 0. Both connection memories reset to all zeros, so every slot starts in switched mode with its driver off.
- R2: In switched mode, the low entry for a slot uses bits 6:5 as the source stream and bits 4:0 as the source channel. `dm_addr` for that stream carries {stream, channel}, and the byte read back on `dm_rdata` is the byte sent in the slot.
- R3: When bit 1 of the stored high entry is 1 (written from `cm_wdata` bit 2), the slot is in message mode. The 8-bit low entry is sent unchanged in that slot, and it is sent again in every following frame.
- R4: When `drive_en` is 1 and `msg_all` is 0, the slot's output-enable equals bit 0 of its high entry (written from `cm_wdata` bit 0), where 1 means driven.
- R5: If `drive_en` is 0 on a clock edge, every `ser_oe` bit is 0 after that edge.
- R6: If `msg_all` is 1 at a slot load, that slot is loaded in message mode with its driver enabled, whatever its high entry holds.
- R7: `cell_pos` bits 7:3 give the channel and bits 2:0 give the bit cell within that channel, and `cell_adv` marks an edge that ends the cell named by `cell_pos`. At an advance edge where bits 2:0 equal 7, the byte for the next channel (channel 31 wraps to 0) is loaded and its bit 7 appears at once. Each later advance edge shifts the next lower bit out.
- R8: While `drive_en` stays high, a slot's output-enable changes only on the edge that loads a new channel.
- R9: `ser_data` changes only on edges where `cell_adv` is 1.
- R10: A write with `cm_we` = 1 targets output stream `cm_waddr[6:5]` and channel `cm_waddr[4:0]`. It goes to the high memory when `cm_hi_sel` is 1 and to the low memory otherwise. A load on the same edge as the write sees the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_pos | input | 8 | Frame position of the cell that is ending: channel (7:3), bit cell (2:0) |
| cell_adv | input | 1 | Bit-cell advance strobe |
| msg_all | input | 1 | Global broadcast-message control |
| drive_en | input | 1 | Global output-drive enable |
| cm_we | input | 1 | Connection-memory write strobe |
| cm_hi_sel | input | 1 | 1 selects the high (control) memory, 0 the low memory |
| cm_waddr | input | 7 | Write address: {output stream, channel} |
| cm_wdata | input | 8 | Write data |
| dm_addr | output | 4x7 | Per-stream data-memory read address |
| dm_rdata | input | 4x8 | Per-stream data-memory read data, combinational return |
| ser_data | output | 4 | Serial data, one bit per output stream |
| ser_oe | output | 4 | Output-enable, one bit per output stream |

## Verification
A wrong connection entry or a wrong source-select decision appears as a wrong byte in exactly one slot. It shows up in the first bit cell of the next frame that serializes that slot, so within 256 cells of the write. A stuck or mis-timed shift register corrupts the very next bit cell on `ser_data`. An enable register that updates at the wrong time changes `ser_oe` in the middle of a byte, which shows within one cell. A wrong global override shows on all four streams at the next channel boundary.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_IDX_W = $clog2(BYTE_W);

  typedef logic [BYTE_W-1:0] slot_byte_t;

  // per-slot control as stored: message select and driver enable
  typedef struct packed {
    logic msg;
    logic drv;
  } slot_ctl_t;
endpackage

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
  parameter int NSTREAM = 4,
  parameter int NCHAN   = 32,
  parameter int W       = 8,
  localparam int SW     = $clog2(NSTREAM),
  localparam int CW     = $clog2(NCHAN),
  localparam int AW     = SW + CW,
  localparam int DEPTH  = NSTREAM * NCHAN
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [AW-1:0]                 waddr,
  input  logic [W-1:0]                  wdata,
  input  logic [CW-1:0]                 rd_ch,
  output logic [NSTREAM-1:0][W-1:0]     rdata
);
  logic [DEPTH-1:0][W-1:0] mem_q;
  logic [DEPTH-1:0][W-1:0] mem_d;

  always_comb begin
    mem_d = mem_q;
    if (we) mem_d[waddr] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_q <= '0;
    else if (we) mem_q <= mem_d;
  end

  // one read port per output stream, all at the same look-ahead channel
  for (genvar s = 0; s < NSTREAM; s++) begin : g_rd
    assign rdata[s] = mem_q[{SW'(s), rd_ch}];
  end
endmodule

// File: rtl/tsi_slot_select.sv
module tsi_slot_select
  import tsi_pkg::*;
#(
  parameter int AW = 7
) (
  input  slot_byte_t     cm_lo,
  input  slot_ctl_t      cm_hi,
  input  logic           msg_all,
  input  slot_byte_t     dm_rdata,
  output logic [AW-1:0]  dm_addr,
  output slot_byte_t     slot_byte,
  output logic           slot_drv
);
  logic use_msg;

  always_comb begin
    dm_addr   = cm_lo[AW-1:0];
    use_msg   = msg_all | cm_hi.msg;
    slot_drv  = msg_all | cm_hi.drv;
    slot_byte = use_msg ? cm_lo : dm_rdata;
  end
endmodule

// File: rtl/tsi_out_lane.sv
module tsi_out_lane
  import tsi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cell_adv,
  input  logic       load,
  input  logic       drive_en,
  input  slot_byte_t byte_in,
  input  logic       drv_in,
  output logic       ser_bit,
  output logic       ser_oe,
  output logic       next_bit
);
  slot_byte_t sh_q, sh_d;
  logic       en_q, en_d;
  logic       oe_q, oe_d;

  always_comb begin
    sh_d = sh_q;
    en_d = en_q;
    if (load) begin
      sh_d = byte_in;
      en_d = drv_in;
    end else if (cell_adv) begin
      sh_d = {sh_q[BYTE_W-2:0], 1'b0};
    end
    oe_d = drive_en & en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      en_q <= 1'b0;
      oe_q <= 1'b0;
    end else begin
      if (cell_adv) sh_q <= sh_d;
      if (load)     en_q <= en_d;
      oe_q <= oe_d;
    end
  end

  assign ser_bit  = sh_q[BYTE_W-1];
  assign ser_oe   = oe_q;
  assign next_bit = sh_q[BYTE_W-2];
endmodule

// File: rtl/tsi_out_engine.sv
module tsi_out_engine
  import tsi_pkg::*;
#(
  parameter int NSTREAM = 4,
  parameter int NCHAN   = 32,
  localparam int SW     = $clog2(NSTREAM),
  localparam int CW     = $clog2(NCHAN),
  localparam int AW     = SW + CW,
  localparam int POS_W  = CW + BIT_IDX_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [POS_W-1:0]               cell_pos,
  input  logic                           cell_adv,
  input  logic                           msg_all,
  input  logic                           drive_en,
  input  logic                           cm_we,
  input  logic                           cm_hi_sel,
  input  logic [AW-1:0]                  cm_waddr,
  input  logic [BYTE_W-1:0]              cm_wdata,
  output logic [NSTREAM-1:0][AW-1:0]     dm_addr,
  input  logic [NSTREAM-1:0][BYTE_W-1:0] dm_rdata,
  output logic [NSTREAM-1:0]             ser_data,
  output logic [NSTREAM-1:0]             ser_oe
);
  localparam int HI_W = $bits(slot_ctl_t);

  logic [CW-1:0]        cur_ch;
  logic [CW-1:0]        nxt_ch;
  logic                 load;
  logic [NSTREAM-1:0]   lane_next;
  logic [NSTREAM-1:0][BYTE_W-1:0] lo_rd;
  logic [NSTREAM-1:0][HI_W-1:0]   hi_rd;
  logic                 we_lo, we_hi;
  logic [HI_W-1:0]      hi_wdata;

  // look-ahead: the last cell of a channel loads the following channel
  always_comb begin
    cur_ch = cell_pos[POS_W-1:BIT_IDX_W];
    nxt_ch = (cur_ch == CW'(NCHAN - 1)) ? '0 : cur_ch + 1'b1;
    load   = cell_adv & (cell_pos[BIT_IDX_W-1:0] == {BIT_IDX_W{1'b1}});
  end

  always_comb begin
    we_lo    = cm_we & ~cm_hi_sel;
    we_hi    = cm_we &  cm_hi_sel;
    hi_wdata = {cm_wdata[2], cm_wdata[0]};
  end

  tsi_conn_mem #(.NSTREAM(NSTREAM), .NCHAN(NCHAN), .W(BYTE_W)) u_cm_lo (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (we_lo),
    .waddr (cm_waddr),
    .wdata (cm_wdata),
    .rd_ch (nxt_ch),
    .rdata (lo_rd)
  );

  tsi_conn_mem #(.NSTREAM(NSTREAM), .NCHAN(NCHAN), .W(HI_W)) u_cm_hi (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (we_hi),
    .waddr (cm_waddr),
    .wdata (hi_wdata),
    .rd_ch (nxt_ch),
    .rdata (hi_rd)
  );

  for (genvar s = 0; s < NSTREAM; s++) begin : g_lane
    slot_byte_t sel_byte;
    logic       sel_drv;

    tsi_slot_select #(.AW(AW)) u_sel (
      .cm_lo     (lo_rd[s]),
      .cm_hi     (slot_ctl_t'(hi_rd[s])),
      .msg_all   (msg_all),
      .dm_rdata  (dm_rdata[s]),
      .dm_addr   (dm_addr[s]),
      .slot_byte (sel_byte),
      .slot_drv  (sel_drv)
    );

    tsi_out_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .cell_adv (cell_adv),
      .load     (load),
      .drive_en (drive_en),
      .byte_in  (sel_byte),
      .drv_in   (sel_drv),
      .ser_bit  (ser_data[s]),
      .ser_oe   (ser_oe[s]),
      .next_bit (lane_next[s])
    );
  end
endmodule

// File: rtl/tsi_out_engine_chk.sv
module tsi_out_engine_chk #(
  parameter int NSTREAM = 4,
  parameter int POS_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [POS_W-1:0]   cell_pos,
  input logic               cell_adv,
  input logic               msg_all,
  input logic               drive_en,
  input logic [NSTREAM-1:0] ser_data,
  input logic [NSTREAM-1:0] ser_oe,
  input logic [NSTREAM-1:0] lane_next
);
  logic edge_load;
  assign edge_load = cell_adv && (cell_pos[2:0] == 3'b111);

  AST_DRIVE_OFF_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |=> (ser_oe == '0)); // R5

  AST_OE_BYTE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(drive_en) && $past(drive_en, 2) && !$past(edge_load)) |-> $stable(ser_oe)); // R8

  AST_BROADCAST_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_all && drive_en && edge_load) |=> (ser_oe == '1)); // R6

  AST_MSB_FIRST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_adv && !edge_load) |=> (ser_data == $past(lane_next))); // R7

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_adv |=> $stable(ser_data)); // R9
endmodule

bind tsi_out_engine tsi_out_engine_chk #(.NSTREAM(NSTREAM), .POS_W(POS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cell_pos  (cell_pos),
  .cell_adv  (cell_adv),
  .msg_all   (msg_all),
  .drive_en  (drive_en),
  .ser_data  (ser_data),
  .ser_oe    (ser_oe),
  .lane_next (lane_next)
);

// File: tb/test_tsi_out_engine.sv
module test_tsi_out_engine;
  logic             clk;
  logic             rst_n;
  logic [7:0]       cell_pos;
  logic             cell_adv;
  logic             msg_all;
  logic             drive_en;
  logic             cm_we;
  logic             cm_hi_sel;
  logic [6:0]       cm_waddr;
  logic [7:0]       cm_wdata;
  logic [3:0][6:0]  dm_addr;
  logic [3:0][7:0]  dm_rdata;
  logic [3:0]       ser_data;
  logic [3:0]       ser_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench models
  logic [7:0] dmem  [128];
  logic [7:0] m_cml [128];
  logic [1:0] m_cmh [128];  // {msg, drv}
  logic [7:0] m_sh  [4];
  logic       m_en  [4];
  logic [3:0] m_oe;
  logic [7:0] shown;
  bit         rand_wr;
  bit         rand_ode;
  int         cap_s, cap_c, cap_cnt;
  logic [7:0] cap, cap_last;

  tsi_out_engine i_tsi_out_engine (
    .clk(clk), .rst_n(rst_n), .cell_pos(cell_pos), .cell_adv(cell_adv),
    .msg_all(msg_all), .drive_en(drive_en), .cm_we(cm_we), .cm_hi_sel(cm_hi_sel),
    .cm_waddr(cm_waddr), .cm_wdata(cm_wdata), .dm_addr(dm_addr), .dm_rdata(dm_rdata),
    .ser_data(ser_data), .ser_oe(ser_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always_comb for (int s = 0; s < 4; s++) dm_rdata[s] = dmem[dm_addr[s]];

  function automatic logic [7:0] slot_byte(input int idx, input bit gm);
    if (gm || m_cmh[idx][1]) return m_cml[idx];
    return dmem[m_cml[idx][6:0]];
  endfunction

  function automatic logic slot_drv(input int idx, input bit gm);
    return gm | m_cmh[idx][0];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // inputs are set before calling; the model is advanced for the coming edge
  task automatic step();
    logic ld;
    logic [4:0] nc;
    ld = cell_adv && (cell_pos[2:0] == 3'b111);
    nc = cell_pos[7:3] + 5'd1;
    for (int s = 0; s < 4; s++) begin
      if (ld) begin
        m_sh[s] = slot_byte(s * 32 + int'(nc), msg_all);
        m_en[s] = slot_drv(s * 32 + int'(nc), msg_all);
      end else if (cell_adv) begin
        m_sh[s] = {m_sh[s][6:0], 1'b0};
      end
      m_oe[s] = drive_en & m_en[s];
    end
    if (cm_we) begin
      if (cm_hi_sel) m_cmh[cm_waddr] = {cm_wdata[2], cm_wdata[0]};
      else           m_cml[cm_waddr] = cm_wdata;
    end
    if (cell_adv) shown = cell_pos + 8'd1;
    @(posedge clk);
    @(negedge clk);
    begin
      logic [3:0] ed;
      for (int s = 0; s < 4; s++) ed[s] = m_sh[s][7];
      check(ser_oe == m_oe, "R4 R5 R6 R8 enable", int'(ser_oe), int'(m_oe));
      check(ser_data == ed, "R2 R3 R7 R9 data", int'(ser_data), int'(ed));
    end
    if (cell_adv && shown[7:3] == cap_c[4:0]) begin
      cap = {cap[6:0], ser_data[cap_s]};
      if (shown[2:0] == 3'd7) begin
        cap_last = cap;
        cap_cnt++;
      end
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      cell_adv = (i % 2) == 1;
      cm_we = 1'b0;
      if (rand_wr && ($urandom % 8) == 0) begin
        cm_we     = 1'b1;
        cm_hi_sel = $urandom % 2;
        cm_waddr  = 7'($urandom);
        cm_wdata  = 8'($urandom);
      end
      if (rand_ode && ($urandom % 16) == 0) drive_en = ~drive_en;
      step();
      if (cell_adv) cell_pos = cell_pos + 8'd1;
    end
    cm_we = 1'b0;
  endtask

  task automatic wr(input bit hi, input logic [6:0] a, input logic [7:0] d);
    cm_we = 1'b1; cm_hi_sel = hi; cm_waddr = a; cm_wdata = d;
    cell_adv = 1'b0;
    step();
    cm_we = 1'b0;
  endtask

  task automatic set_cap(input int s, input int c);
    cap_s = s; cap_c = c; cap_cnt = 0; cap = '0; cap_last = '0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; cell_pos = '0; cell_adv = 1'b0; msg_all = 1'b0; drive_en = 1'b0;
    cm_we = 1'b0; cm_hi_sel = 1'b0; cm_waddr = '0; cm_wdata = '0;
    rand_wr = 0; rand_ode = 0; set_cap(0, 0);
    for (int i = 0; i < 128; i++) begin
      dmem[i] = 8'($urandom); m_cml[i] = '0; m_cmh[i] = '0;
    end
    dmem[{2'd2, 5'd19}] = 8'hA6;
    for (int s = 0; s < 4; s++) begin m_sh[s] = '0; m_en[s] = 1'b0; end
    m_oe = '0; shown = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check(ser_oe == 4'h0, "R1 reset enable", int'(ser_oe), 0);
    check(ser_data == 4'h0, "R1 reset data", int'(ser_data), 0);
    drive_en = 1'b1;
    run(520);  // R1: cleared memories keep all drivers off for a frame

    // random programming and traffic
    rand_wr = 1;
    run(2048);
    rand_wr = 0;

    // R2 R10: stream 1 channel 7 takes input stream 2 channel 19
    wr(1'b0, {2'd1, 5'd7}, 8'h53);
    wr(1'b1, {2'd1, 5'd7}, 8'h01);
    set_cap(1, 7);
    run(1024);
    check(cap_last == 8'hA6, "R2 switched byte", int'(cap_last), 'hA6);
    check(cap_cnt >= 1, "R10 slot reached", cap_cnt, 1);

    // R3: message byte repeats every frame
    wr(1'b0, {2'd3, 5'd0}, 8'h3C);
    wr(1'b1, {2'd3, 5'd0}, 8'h05);
    set_cap(3, 0);
    run(1540);
    check(cap_last == 8'h3C, "R3 message byte", int'(cap_last), 'h3C);
    check(cap_cnt >= 2, "R3 repeat count", cap_cnt, 2);

    // R6: broadcast overrides a switched, disabled slot
    wr(1'b0, {2'd0, 5'd5}, 8'h81);
    wr(1'b1, {2'd0, 5'd5}, 8'h00);
    msg_all = 1'b1;
    set_cap(0, 5);
    run(1024);
    check(cap_last == 8'h81, "R6 broadcast byte", int'(cap_last), 'h81);
    msg_all = 1'b0;

    // R4 R5 R8: random drive-enable with random programming
    rand_wr = 1; rand_ode = 1;
    run(1024);
    rand_wr = 0; rand_ode = 0;
    drive_en = 1'b0;
    cell_adv = 1'b0;
    step();
    check(ser_oe == 4'h0, "R5 drive off", int'(ser_oe), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule